// File: doc/BRIEF.md
# Tagged Result Frame Packer

The packer takes 32-bit result words, each marked with a 4-bit source tag, and groups them into fixed frames of 32 bytes for a byte-wide FIFO that leads to a host. A frame has eight 32-bit words. The first is a status word that records, one nibble per slot, which source filled each of the seven data slots that follow it. The data slots hold the results in the order they arrived.

A frame is closed and sent in two cases. The first is when the seventh result arrives. The second is when a partly filled frame has seen no new result for `QUIET_LIMIT` cycles; the unused slots are then padded. When no frame is waiting and the FIFO can take data, the packer fills the link with a fixed idle word that the host skips four bytes at a time. An idle word is never split, and it never appears inside a frame. While a closed frame waits or is being sent, the input is held off.

Top module: `fp_frame_packer`

## Requirements
- R1: While reset is applied, and until the first output decision after reset, `out_valid` is low and `in_ready` is high.
- R2: A frame is 32 bytes: the status word first, then the words of data slots 0 to 6. Each word goes out least-significant byte first, so status word 0xEFFFFFF3 leaves as F3, FF, FF, EF.
- R3: Status word bits [31:28] are 0xE. Bits [4i+3:4i] hold the tag of data slot i, for i = 0 to 6.
- R4: A slot with no result carries tag nibble 0xF in the status word and the data word 0xFFFFFFFF.
- R5: A result is taken when `in_valid` and `in_ready` are both high. After the seventh result of a frame is taken, `in_ready` stays low until the last byte of that frame has been accepted.
- R6: A frame holding one to six results is closed after `QUIET_LIMIT` consecutive cycles in which no result was taken. It is then sent padded.
- R7: The idle word 0x55556666 (bytes 66, 66, 55, 55) starts only in a cycle where nothing is being sent, `out_ready` is high, and no frame is closed. An idle word that has started is finished before any frame byte.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_byte` hold their values.
- R9: Results fill the slots in arrival order, starting at slot 0. The slot contents and tags are reproduced exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| in_valid | input | 1 | A result is offered |
| in_ready | output | 1 | The packer can take a result |
| in_data | input | 32 | Result word |
| in_tag | input | 4 | Source tag of the result |
| out_valid | output | 1 | `out_byte` holds a byte to send |
| out_ready | input | 1 | The FIFO takes the byte this cycle |
| out_byte | output | 8 | Output byte |

## Verification
Two cases can fall in the same cycle. The first is the timeout expiring in the cycle a new result arrives. The taken result must win, and the quiet count must restart. The second is a frame closing while an idle word is partly sent. The idle word must finish before the status byte follows. Both are provoked by a directed timeout phase and by long phases of random `in_valid` and `out_ready` at differing rates. A queue-based model predicts `in_ready`, `out_valid` and `out_byte` every clock and judges each cycle against them.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int SLOT_N   = 7;
  localparam int WORD_W   = 32;
  localparam int TAG_W    = 4;
  localparam int BYTE_W   = 8;
  localparam int WORD_N   = SLOT_N + 1;
  localparam int IDX_W    = $clog2(WORD_N);
  localparam int LANE_N   = WORD_W / BYTE_W;
  localparam int LANE_W   = $clog2(LANE_N);
  localparam logic [WORD_W-1:0] IDLE_WORD = 32'h5555_6666;
  localparam logic [TAG_W-1:0]  HDR_MARK  = 4'hE;
  localparam logic [TAG_W-1:0]  EMPTY_TAG = 4'hF;

  typedef enum logic [1:0] {
    EM_GAP   = 2'd0,
    EM_IDLE  = 2'd1,
    EM_FRAME = 2'd2
  } emit_state_e;
endpackage

// File: rtl/fp_rst_sync.sv
module fp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_o = s2_q;
endmodule

// File: rtl/fp_slot_store.sv
module fp_slot_store
  import fp_pkg::*;
#(
  parameter int QUIET_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              in_ready,
  input  logic              frame_done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              sealed_o,
  output logic [IDX_W-1:0]  fill_o
);
  localparam int QW = $clog2(QUIET_LIMIT + 1);

  logic [WORD_W-1:0] data_q [SLOT_N];
  logic [TAG_W-1:0]  tag_q  [SLOT_N];
  logic [IDX_W-1:0]  fill_q, fill_d;
  logic              sealed_q, sealed_d;
  logic [QW-1:0]     quiet_q, quiet_d;
  logic              accept;
  logic [WORD_W-1:0] hdr;
  logic [WORD_W-1:0] words [WORD_N];

  assign accept   = in_valid && !sealed_q;
  assign in_ready = !sealed_q;
  assign sealed_o = sealed_q;
  assign fill_o   = fill_q;

  // next-state for fill level, seal flag and quiet timer
  always_comb begin
    fill_d   = fill_q;
    sealed_d = sealed_q;
    quiet_d  = quiet_q;
    if (frame_done) begin
      fill_d   = '0;
      sealed_d = 1'b0;
      quiet_d  = '0;
    end else if (accept) begin
      fill_d  = fill_q + 1'b1;
      quiet_d = '0;
      if (fill_q == IDX_W'(SLOT_N - 1)) sealed_d = 1'b1;
    end else if (fill_q != '0 && !sealed_q) begin
      if (quiet_q == QW'(QUIET_LIMIT - 1)) begin
        sealed_d = 1'b1;
        quiet_d  = '0;
      end else begin
        quiet_d = quiet_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= '0;
      sealed_q <= 1'b0;
      quiet_q  <= '0;
    end else begin
      fill_q   <= fill_d;
      sealed_q <= sealed_d;
      quiet_q  <= quiet_d;
    end
  end

  // per-slot storage, padding applied on the read side
  for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
    logic wr_en;
    logic used;
    assign wr_en = accept && (fill_q == IDX_W'(i));
    assign used  = fill_q > IDX_W'(i);

    always_ff @(posedge clk) begin
      if (wr_en) begin
        data_q[i] <= in_data;
        tag_q[i]  <= in_tag;
      end
    end

    assign hdr[TAG_W*i +: TAG_W] = used ? tag_q[i] : EMPTY_TAG;
    assign words[i+1]            = used ? data_q[i] : '1;
  end

  assign hdr[WORD_W-1 -: TAG_W] = HDR_MARK;
  assign words[0] = hdr;
  assign rd_word  = words[rd_idx];
endmodule

// File: rtl/fp_byte_emitter.sv
module fp_byte_emitter
  import fp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              sealed,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  output logic              frame_done,
  output emit_state_e       state_o,
  output logic [LANE_W-1:0] lane_o
);
  emit_state_e       state_q, state_d;
  logic [IDX_W-1:0]  word_q, word_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              fire;
  logic              last_lane;
  logic [WORD_W-1:0] cur_word;
  logic [BYTE_W-1:0] lanes [LANE_N];

  assign out_valid = (state_q != EM_GAP);
  assign fire      = out_valid && out_ready;
  assign last_lane = (lane_q == LANE_W'(LANE_N - 1));
  assign cur_word  = (state_q == EM_FRAME) ? rd_word : IDLE_WORD;
  assign rd_idx    = word_q;
  assign state_o   = state_q;
  assign lane_o    = lane_q;

  for (genvar b = 0; b < LANE_N; b++) begin : g_lane
    assign lanes[b] = cur_word[BYTE_W*b +: BYTE_W];
  end
  assign out_byte = lanes[lane_q];

  assign frame_done = fire && (state_q == EM_FRAME) && last_lane &&
                      (word_q == IDX_W'(WORD_N - 1));

  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    lane_d  = lane_q;
    unique case (state_q)
      EM_GAP: begin
        if (sealed)         state_d = EM_FRAME;
        else if (out_ready) state_d = EM_IDLE;
      end
      EM_IDLE: begin
        if (fire) begin
          lane_d = lane_q + 1'b1;
          if (last_lane) state_d = EM_GAP;
        end
      end
      EM_FRAME: begin
        if (fire) begin
          lane_d = lane_q + 1'b1;
          if (last_lane) begin
            word_d = word_q + 1'b1;
            if (word_q == IDX_W'(WORD_N - 1)) state_d = EM_GAP;
          end
        end
      end
      default: state_d = EM_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EM_GAP;
      word_q  <= '0;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      lane_q  <= lane_d;
    end
  end
endmodule

// File: rtl/fp_frame_packer.sv
module fp_frame_packer
  import fp_pkg::*;
#(
  parameter int QUIET_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic [3:0]  in_tag,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_byte
);
  logic              rst_i;
  logic              sealed;
  logic              frame_done;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  fill;
  logic [WORD_W-1:0] rd_word;
  emit_state_e       emit_state;
  logic [LANE_W-1:0] lane;

  fp_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_o (rst_i)
  );

  fp_slot_store #(.QUIET_LIMIT(QUIET_LIMIT)) u_store (
    .clk        (clk),
    .rst_ni     (rst_i),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_tag     (in_tag),
    .in_ready   (in_ready),
    .frame_done (frame_done),
    .rd_idx     (rd_idx),
    .rd_word    (rd_word),
    .sealed_o   (sealed),
    .fill_o     (fill)
  );

  fp_byte_emitter u_emit (
    .clk        (clk),
    .rst_ni     (rst_i),
    .sealed     (sealed),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .rd_idx     (rd_idx),
    .rd_word    (rd_word),
    .frame_done (frame_done),
    .state_o    (emit_state),
    .lane_o     (lane)
  );
endmodule

// File: rtl/fp_frame_packer_chk.sv
module fp_frame_packer_chk
  import fp_pkg::*;
#(
  parameter int QUIET_LIMIT = 16
) (
  input logic              clk,
  input logic              rst_i,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_byte,
  input logic              sealed,
  input logic              frame_done,
  input logic [IDX_W-1:0]  fill,
  input logic [IDX_W-1:0]  rd_idx,
  input emit_state_e       emit_state,
  input logic [LANE_W-1:0] lane
);
  localparam int QW = $clog2(QUIET_LIMIT + 2);

  logic          accept;
  logic [3:0]    acc_cnt;
  logic [QW-1:0] quiet_mon;

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      acc_cnt   <= '0;
      quiet_mon <= '0;
    end else begin
      if (frame_done)  acc_cnt <= '0;
      else if (accept) acc_cnt <= acc_cnt + 1'b1;
      if (frame_done || accept) quiet_mon <= '0;
      else if (fill != '0 && !sealed && quiet_mon != QW'(QUIET_LIMIT + 1))
        quiet_mon <= quiet_mon + 1'b1;
    end
  end

  // R5
  accept_limit_chk: assert property (@(posedge clk) disable iff (!rst_i)
    acc_cnt <= 4'(SLOT_N));

  // R5
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (acc_cnt == 4'(SLOT_N)) |-> !in_ready);

  // R6
  quiet_seal_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (quiet_mon == QW'(QUIET_LIMIT)) |-> sealed);

  // R3
  hdr_mark_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (emit_state == EM_FRAME && rd_idx == '0 && lane == LANE_W'(LANE_N - 1))
      |-> out_byte[7:4] == HDR_MARK);

  // R7
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (emit_state == EM_IDLE && $past(emit_state) == EM_GAP)
      |-> ($past(out_ready) && !$past(sealed)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
endmodule

bind fp_frame_packer fp_frame_packer_chk #(.QUIET_LIMIT(QUIET_LIMIT)) u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_byte   (out_byte),
  .sealed     (sealed),
  .frame_done (frame_done),
  .fill       (fill),
  .rd_idx     (rd_idx),
  .emit_state (emit_state),
  .lane       (lane)
);

// File: tb/test_fp_frame_packer.sv
module test_fp_frame_packer;
  localparam int LIMIT = 12;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic [3:0]  in_tag;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit chk_en = 0;

  // reference model state
  logic [35:0] res_q[$];
  logic [7:0]  byte_q[$];
  int          why_q[$];
  bit          m_sealed;
  int          m_quiet;
  int          m_mode;
  int          sync;

  fp_frame_packer #(.QUIET_LIMIT(LIMIT)) i_fp_frame_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_tag    (in_tag),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic push_word(input logic [31:0] w, input int why);
    for (int b = 0; b < 4; b++) begin
      byte_q.push_back(w[8*b +: 8]);
      why_q.push_back(why);
    end
  endtask

  // R2 R3 R4 R9: frame built from the queued results
  task automatic build_frame();
    logic [31:0] hdr;
    hdr = 32'hE000_0000;
    for (int i = 0; i < 7; i++)
      hdr[4*i +: 4] = (i < res_q.size()) ? res_q[i][35:32] : 4'hF;
    push_word(hdr, 3);
    for (int i = 0; i < 7; i++) begin
      if (i < res_q.size()) push_word(res_q[i][31:0], 9);
      else push_word(32'hFFFF_FFFF, 4);
    end
  endtask

  always @(posedge clk) begin
    chk_en <= 1'b1;
    if (!rst_n) begin
      res_q.delete(); byte_q.delete(); why_q.delete();
      m_sealed = 0; m_quiet = 0; m_mode = 0; sync = 0;
    end else if (sync < 2) begin
      sync++;
    end else begin
      bit acc, fin;
      acc = in_valid && !m_sealed;
      fin = 0;
      if (byte_q.size() > 0) begin
        if (out_ready) begin
          void'(byte_q.pop_front()); void'(why_q.pop_front());
          if (byte_q.size() == 0) begin
            if (m_mode == 2) fin = 1;
            m_mode = 0;
          end
        end
      end else if (m_sealed) begin
        build_frame(); m_mode = 2;
      end else if (out_ready) begin
        push_word(32'h5555_6666, 7); m_mode = 1;   // R7
      end
      if (fin) begin
        res_q.delete(); m_sealed = 0; m_quiet = 0;
      end else if (acc) begin
        res_q.push_back({in_tag, in_data}); m_quiet = 0;
        if (res_q.size() == 7) m_sealed = 1;        // R5
      end else if (res_q.size() > 0 && !m_sealed) begin
        m_quiet++;
        if (m_quiet == LIMIT) begin m_sealed = 1; m_quiet = 0; end  // R6
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      if (!rst_n || sync < 2) begin
        // R1
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
          fails++;
          $display("FAIL R1 reset: out_valid=%b in_ready=%b expected 0/1", out_valid, in_ready);
        end
      end else begin
        // R5
        checks++;
        if (in_ready !== !m_sealed) begin
          fails++;
          $display("FAIL R5 in_ready=%b expected %b", in_ready, !m_sealed);
        end
        // R2 R8: valid follows the pending byte queue, held through stalls
        checks++;
        if (out_valid !== (byte_q.size() > 0)) begin
          fails++;
          $display("FAIL R2 out_valid=%b expected %b", out_valid, byte_q.size() > 0);
        end else if (out_valid) begin
          checks++;
          if (out_byte !== byte_q[0]) begin
            fails++;
            $display("FAIL R%0d out_byte=%h expected %h", why_q[0], out_byte, byte_q[0]);
          end
        end
      end
    end
  end

  task automatic phase(input int n, input int pv, input int pr);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      in_valid  = ($urandom_range(99, 0) < pv);
      in_data   = $urandom;
      in_tag    = 4'($urandom_range(14, 0));
      out_ready = ($urandom_range(99, 0) < pr);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_tag = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    phase(4, 0, 0);          // R1 reset release, nothing offered
    phase(12, 100, 0);       // R5 R9 full frame, output stalled (R8)
    phase(60, 0, 100);       // R2 R3 drain, then idle words (R7)
    phase(3, 100, 100);      // R6 three results then quiet
    phase(50, 0, 100);       // R4 padded frame after timeout
    phase(9, 30, 40);        // R6 accept near timeout boundary
    phase(2000, 50, 70);
    phase(1500, 8, 50);
    phase(1500, 90, 20);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule